// File: doc/BRIEF.md
# Machine Cycle Bus Sequencer

This block drives the external bus of a small 8-bit processor core with a 16-bit address space, for three instructions. Each instruction is split into timed machine cycles, and each machine cycle into numbered clocks (T1 to T4). In every machine cycle the sequencer puts the address on the bus, pulses the address latch strobe, runs a read or write strobe and reports the cycle type. It also holds the architectural state these instructions touch: the program counter, the stack pointer, the accumulator and the B and C byte registers.

The bus is multiplexed. In T1 the low address byte goes out on `ad_out` with `ad_oe` high, `ale` marks it for an external latch, and the high byte sits on `a_hi` for the whole cycle. From T2 the low lane carries data. In a read cycle it is driven by the outside onto `ad_in` and captured at the end of T3. In a write cycle the block drives it. The bus controls flow with `ready`, the only back-pressure in the design. It is sampled at the end of every T2. While it is low, T2 repeats as a wait clock with the strobes, the address and the cycle type held. Nothing is lost and nothing is skipped. The instruction only takes longer, by one clock per wait.

The supported opcodes are C1h (pop a byte pair from the stack into C then B), 3Ah (load the accumulator from a direct 16-bit address) and D3h (write the accumulator to an 8-bit port). Any other opcode byte finishes after its fetch cycle as a four-clock no-op. After reset the sequencer fetches from address 0000h and runs one instruction after another.

Top module: `mcs_top`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `rd_n` and `wr_n` are 1 and `done` is 0. The program counter reads 0000h and the stack pointer reads `SP_INIT` (default 0F00h). The first clock after release is T1 of an opcode fetch at 0000h.
- R2: An opcode fetch lasts four clocks plus waits. It reads memory at the program counter, has cycle type 00, and the program counter increments once at its end. An opcode with no defined meaning ends the instruction after this one cycle, so the total is 4 clocks plus waits.
- R3: Every machine cycle starts with exactly one `ale` clock, T1. In T1 `ad_oe` is 1, `ad_out` carries address bits 7:0 and `a_hi` carries bits 15:8. Memory read and I/O write cycles last three clocks plus waits.
- R4: `ready` is sampled at the end of each T2, including T2 of an opcode fetch. Each low sample adds one wait clock in which the active strobe stays low and `a_hi` and `cyc_type` do not change.
- R5: Opcode C1h performs a fetch followed by two memory reads at SP and SP+1. The first byte read goes to C and the second to B. SP ends 2 higher and PC ends 1 higher. The instruction takes 10 clocks plus waits.
- R6: Opcode 3Ah performs a fetch, then reads the low and the high address byte from PC+1 and PC+2, then a memory read at that 16-bit address whose byte loads the accumulator. PC ends 3 higher. The instruction takes 13 clocks plus waits.
- R7: Opcode D3h performs a fetch, then a memory read of the port byte at PC+1, then an I/O write cycle. In that cycle the port number is on both address bytes and `ad_out` carries the accumulator while `wr_n` is low. PC ends 2 higher. The instruction takes 10 clocks plus waits.
- R8: `cyc_type` codes are 00 opcode fetch, 01 memory read, 10 memory write, 11 I/O write. `io_m` is 1 exactly in I/O write cycles, and `wr_n` goes low only in them.
- R9: `done` is high for one clock: the last clock of each instruction. The next clock is T1 of an opcode fetch.
- R10: `rd_n` and `wr_n` are never low together. In a cycle that has a strobe, it is low from T2 through T3, including the wait clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready | input | 1 | Bus ready; low at the end of T2 inserts a wait clock |
| ad_in | input | 8 | Read data from the multiplexed bus |
| ad_out | output | 8 | Low address byte in T1, write data afterwards |
| ad_oe | output | 1 | Block drives the multiplexed bus |
| a_hi | output | 8 | High address byte for the whole cycle |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| cyc_type | output | 2 | Machine cycle type code |
| done | output | 1 | Last clock of an instruction |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | Register B |
| c_q | output | 8 | Register C |

## Verification
The wait-state properties assume that `ready` goes low only in response to an active strobe, that it is released within a few clocks, and that read data is valid on `ad_in` at the end of T3. The cycle-length property assumes no reset arrives inside the cycle being measured. The stimulus meets these conditions. Its memory model answers from the address it latched in T1, its wait generator arms on `ale` and counts its wait clocks only while a strobe is low, and the one mid-instruction reset clears the checker's record of the previous cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // bus cycle type reported on cyc_type
  typedef enum logic [1:0] {
    CY_OF  = 2'd0,
    CY_MR  = 2'd1,
    CY_MW  = 2'd2,
    CY_IOW = 2'd3
  } cyc_e;

  // clock position inside one machine cycle
  typedef enum logic [1:0] {
    TS1, TS2, TS3, TS4
  } tst_e;

  // machine cycle position inside one instruction
  typedef enum logic [2:0] {
    ST_FETCH,
    ST_POP_LO,
    ST_POP_HI,
    ST_LDA_LO,
    ST_LDA_HI,
    ST_LDA_DAT,
    ST_OUT_PORT,
    ST_OUT_WR
  } step_e;

  // byte register file layout
  localparam int NREG  = 3;
  localparam int REG_A = 0;
  localparam int REG_B = 1;
  localparam int REG_C = 2;

endpackage

// File: rtl/mcs_tstate.sv
// Clock counter inside one machine cycle, with wait insertion at T2.
module mcs_tstate
  import mcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic long_cyc,   // cycle has a fourth clock (opcode fetch)
  output tst_e tst,
  output logic cyc_last    // current clock is the last of the cycle
);

  tst_e nxt;

  always_comb begin
    nxt      = tst;
    cyc_last = 1'b0;
    unique case (tst)
      TS1: nxt = TS2;
      TS2: if (ready) nxt = TS3;
      TS3: begin
        if (long_cyc) begin
          nxt = TS4;
        end else begin
          nxt      = TS1;
          cyc_last = 1'b1;
        end
      end
      TS4: begin
        nxt      = TS1;
        cyc_last = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tst <= TS1;
    else        tst <= nxt;
  end

endmodule

// File: rtl/mcs_ctrl.sv
// Instruction step sequencing, operand capture and register update strobes.
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] OPC_POP = 8'hC1,
  parameter logic [DATA_W-1:0] OPC_LDA = 8'h3A,
  parameter logic [DATA_W-1:0] OPC_OUT = 8'hD3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tst_e                tst,
  input  logic                cyc_last,
  input  logic [DATA_W-1:0]   din,
  output step_e               step,
  output logic                done,
  output logic                pc_inc,
  output logic                sp_inc,
  output logic [NREG-1:0]     ld_reg,
  output logic [2*DATA_W-1:0] dir_addr,
  output logic [DATA_W-1:0]   port
);

  logic [DATA_W-1:0] ir_q, lo_q, hi_q, port_q;
  logic              cap;
  step_e             nxt, dec;

  assign cap      = (tst == TS3);
  assign dir_addr = {hi_q, lo_q};
  assign port     = port_q;

  always_comb begin
    if      (ir_q == OPC_POP) dec = ST_POP_LO;
    else if (ir_q == OPC_LDA) dec = ST_LDA_LO;
    else if (ir_q == OPC_OUT) dec = ST_OUT_PORT;
    else                      dec = ST_FETCH;
  end

  always_comb begin
    nxt    = step;
    done   = 1'b0;
    pc_inc = 1'b0;
    sp_inc = 1'b0;
    ld_reg = '0;
    if (cyc_last) begin
      unique case (step)
        ST_FETCH: begin
          pc_inc = 1'b1;
          nxt    = dec;
          done   = (dec == ST_FETCH);
        end
        ST_POP_LO: begin
          sp_inc        = 1'b1;
          ld_reg[REG_C] = 1'b1;
          nxt           = ST_POP_HI;
        end
        ST_POP_HI: begin
          sp_inc        = 1'b1;
          ld_reg[REG_B] = 1'b1;
          nxt           = ST_FETCH;
          done          = 1'b1;
        end
        ST_LDA_LO: begin
          pc_inc = 1'b1;
          nxt    = ST_LDA_HI;
        end
        ST_LDA_HI: begin
          pc_inc = 1'b1;
          nxt    = ST_LDA_DAT;
        end
        ST_LDA_DAT: begin
          ld_reg[REG_A] = 1'b1;
          nxt           = ST_FETCH;
          done          = 1'b1;
        end
        ST_OUT_PORT: begin
          pc_inc = 1'b1;
          nxt    = ST_OUT_WR;
        end
        ST_OUT_WR: begin
          nxt  = ST_FETCH;
          done = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_FETCH;
      ir_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      port_q <= '0;
    end else begin
      step <= nxt;
      if (cap && step == ST_FETCH)    ir_q   <= din;
      if (cap && step == ST_LDA_LO)   lo_q   <= din;
      if (cap && step == ST_LDA_HI)   hi_q   <= din;
      if (cap && step == ST_OUT_PORT) port_q <= din;
    end
  end

endmodule

// File: rtl/mcs_regs.sv
// Pointer registers and byte registers.
module mcs_regs
  import mcs_pkg::*;
#(
  parameter int                  DATA_W  = 8,
  parameter logic [2*DATA_W-1:0] SP_INIT = 16'h0F00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pc_inc,
  input  logic                         sp_inc,
  input  logic [NREG-1:0]              ld_reg,
  input  logic [DATA_W-1:0]            din,
  output logic [2*DATA_W-1:0]          pc,
  output logic [2*DATA_W-1:0]          sp,
  output logic [NREG-1:0][DATA_W-1:0]  dat
);

  localparam int ADDR_W = 2 * DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      sp <= SP_INIT;
    end else begin
      if (pc_inc) pc <= pc + ADDR_W'(1);
      if (sp_inc) sp <= sp + ADDR_W'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_breg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dat[g] <= '0;
      else if (ld_reg[g]) dat[g] <= din;
    end
  end

endmodule

// File: rtl/mcs_top.sv
// Machine cycle bus sequencer: bus drive and address selection.
module mcs_top
  import mcs_pkg::*;
#(
  parameter int                  DATA_W  = 8,
  parameter logic [2*DATA_W-1:0] SP_INIT = 16'h0F00,
  parameter logic [DATA_W-1:0]   OPC_POP = 8'hC1,
  parameter logic [DATA_W-1:0]   OPC_LDA = 8'h3A,
  parameter logic [DATA_W-1:0]   OPC_OUT = 8'hD3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready,
  input  logic [DATA_W-1:0]   ad_in,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic [DATA_W-1:0]   a_hi,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic                io_m,
  output logic [1:0]          cyc_type,
  output logic                done,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [2*DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0]   acc_q,
  output logic [DATA_W-1:0]   b_q,
  output logic [DATA_W-1:0]   c_q
);

  localparam int ADDR_W = 2 * DATA_W;

  tst_e                       tst;
  step_e                      step;
  cyc_e                       cyc;
  logic                       cyc_last, long_cyc;
  logic                       pc_inc, sp_inc;
  logic [NREG-1:0]            ld_reg;
  logic [NREG-1:0][DATA_W-1:0] dat;
  logic [ADDR_W-1:0]          pc, sp, dir_addr, addr;
  logic [DATA_W-1:0]          port;
  logic                       is_rd, is_wr, strobe_ph;

  assign long_cyc = (step == ST_FETCH);

  mcs_tstate u_tst (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .long_cyc (long_cyc),
    .tst      (tst),
    .cyc_last (cyc_last)
  );

  mcs_ctrl #(
    .DATA_W  (DATA_W),
    .OPC_POP (OPC_POP),
    .OPC_LDA (OPC_LDA),
    .OPC_OUT (OPC_OUT)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tst      (tst),
    .cyc_last (cyc_last),
    .din      (ad_in),
    .step     (step),
    .done     (done),
    .pc_inc   (pc_inc),
    .sp_inc   (sp_inc),
    .ld_reg   (ld_reg),
    .dir_addr (dir_addr),
    .port     (port)
  );

  mcs_regs #(
    .DATA_W  (DATA_W),
    .SP_INIT (SP_INIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_inc (pc_inc),
    .sp_inc (sp_inc),
    .ld_reg (ld_reg),
    .din    (ad_in),
    .pc     (pc),
    .sp     (sp),
    .dat    (dat)
  );

  always_comb begin
    unique case (step)
      ST_FETCH:  cyc = CY_OF;
      ST_OUT_WR: cyc = CY_IOW;
      default:   cyc = CY_MR;
    endcase
  end

  always_comb begin
    unique case (step)
      ST_POP_LO, ST_POP_HI: addr = sp;
      ST_LDA_DAT:           addr = dir_addr;
      ST_OUT_WR:            addr = {port, port};
      default:              addr = pc;
    endcase
  end

  assign is_wr     = (cyc == CY_IOW) || (cyc == CY_MW);
  assign is_rd     = !is_wr;
  assign strobe_ph = (tst == TS2) || (tst == TS3);

  assign ale      = rst_n && (tst == TS1);
  assign ad_oe    = rst_n && ((tst == TS1) || (is_wr && strobe_ph));
  assign ad_out   = (tst == TS1) ? addr[DATA_W-1:0] : dat[REG_A];
  assign a_hi     = addr[ADDR_W-1:DATA_W];
  assign rd_n     = !(is_rd && strobe_ph);
  assign wr_n     = !(is_wr && strobe_ph);
  assign io_m     = (cyc == CY_IOW);
  assign cyc_type = cyc;

  assign pc_q  = pc;
  assign sp_q  = sp;
  assign acc_q = dat[REG_A];
  assign b_q   = dat[REG_B];
  assign c_q   = dat[REG_C];

endmodule

// File: rtl/mcs_chk.sv
// Protocol checker for mcs_top, attached by bind.
module mcs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              io_m,
  input logic [1:0]        cyc_type,
  input logic [DATA_W-1:0] a_hi,
  input logic              done
);

  logic       t2_q, seen_q;
  logic [7:0] len_q, wt_q;
  logic [1:0] prev_ty;

  // clocks and waits of the current machine cycle, tracked from ale
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2_q    <= 1'b0;
      seen_q  <= 1'b0;
      len_q   <= '0;
      wt_q    <= '0;
      prev_ty <= 2'd0;
    end else if (ale) begin
      t2_q    <= 1'b1;
      seen_q  <= 1'b1;
      len_q   <= 8'd1;
      wt_q    <= '0;
      prev_ty <= cyc_type;
    end else begin
      len_q <= len_q + 8'd1;
      if (t2_q && !ready) wt_q <= wt_q + 8'd1;
      if (t2_q && ready)  t2_q <= 1'b0;
    end
  end

  // R1: strobes idle during reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (rd_n && wr_n && !ale && !done));

  // R2, R3: cycle length without waits is 4 for a fetch and 3 otherwise
  a_r2_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && seen_q) |-> ((len_q - wt_q) == ((prev_ty == 2'd0) ? 8'd4 : 8'd3)));

  // R3: ale lasts a single clock
  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4: a low ready in T2 holds strobe, address and type
  a_r4_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_q && !ready) |=> ((!rd_n || !wr_n) && $stable(a_hi) && $stable(cyc_type)));

  // R10: strobe is active throughout T2
  a_r10_strobe_t2: assert property (@(posedge clk) disable iff (!rst_n)
    t2_q |-> (!rd_n || !wr_n));

  // R10: never both strobes at once
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R8: writes only in I/O write cycles, io_m starts with a cycle
  a_r8_wr_iow: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (cyc_type == 2'd3 && io_m));

  a_r8_io_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_m) |-> ale);

  // R9: done is a single clock and is followed by an opcode fetch
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ale && cyc_type == 2'd0));

endmodule

bind mcs_top mcs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .io_m     (io_m),
  .cyc_type (cyc_type),
  .a_hi     (a_hi),
  .done     (done)
);

// File: tb/sim_mcs_top.sv
module sim_mcs_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready = 1'b1;
  logic [7:0]  ad_in, ad_out, a_hi, acc_q, b_q, c_q;
  logic        ad_oe, ale, rd_n, wr_n, io_m, done;
  logic [1:0]  cyc_type;
  logic [15:0] pc_q, sp_q;

  always #5 clk = ~clk;

  mcs_top u0 (
    .clk (clk), .rst_n (rst_n), .ready (ready), .ad_in (ad_in),
    .ad_out (ad_out), .ad_oe (ad_oe), .a_hi (a_hi), .ale (ale),
    .rd_n (rd_n), .wr_n (wr_n), .io_m (io_m), .cyc_type (cyc_type),
    .done (done), .pc_q (pc_q), .sp_q (sp_q), .acc_q (acc_q),
    .b_q (b_q), .c_q (c_q)
  );

  // memory model answering from the latched address
  logic [7:0]  mem [0:4095];
  logic [15:0] lat = 16'h0;
  assign ad_in = !rd_n ? mem[lat[11:0]] : 8'h00;

  int checks = 0;
  int fails  = 0;
  int nwait  = 0;
  int both_low = 0;

  // per-instruction record, built by the monitor
  int         clkcnt, ncyc, rem;
  logic       armed, wr_seen;
  logic [1:0]  lg_ty [8];
  logic [15:0] lg_ad [8];
  logic        lg_io [8];
  logic        lg_oe [8];
  logic [7:0]  wr_d, wr_p;
  int          r_len, r_ncyc;
  logic [1:0]  r_ty [8];
  logic [15:0] r_ad [8];
  logic        r_io [8];
  logic        r_oe [8];
  logic [7:0]  r_wd, r_wp;
  logic        r_ws;
  event        ev_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      clkcnt = 0; ncyc = 0; rem = 0; armed = 1'b0; wr_seen = 1'b0; ready = 1'b1;
    end else begin
      clkcnt++;
      if (!rd_n && !wr_n) both_low++;
      if (ale) begin
        lat = {a_hi, ad_out};
        if (ncyc < 8) begin
          lg_ty[ncyc] = cyc_type; lg_ad[ncyc] = lat;
          lg_io[ncyc] = io_m;     lg_oe[ncyc] = ad_oe;
        end
        ncyc++;
        armed = 1'b1;
      end
      if (!rd_n || !wr_n) begin
        if (armed) begin rem = nwait; armed = 1'b0; end
        if (rem > 0) begin ready = 1'b0; rem--; end
        else ready = 1'b1;
      end
      if (!wr_n && !wr_seen) begin
        wr_seen = 1'b1; wr_d = ad_out; wr_p = lat[7:0];
      end
      if (done) begin
        r_len = clkcnt; r_ncyc = ncyc; r_wd = wr_d; r_wp = wr_p; r_ws = wr_seen;
        for (int i = 0; i < 8; i++) begin
          r_ty[i] = lg_ty[i]; r_ad[i] = lg_ad[i]; r_io[i] = lg_io[i]; r_oe[i] = lg_oe[i];
        end
        clkcnt = 0; ncyc = 0; wr_seen = 1'b0;
        -> ev_done;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_cyc(input string req, input int k, input logic [1:0] ty,
                           input logic [15:0] ad, input logic io);
    check({req, " cycle type"}, 32'(r_ty[k]), 32'(ty));
    check({req, " cycle address"}, 32'(r_ad[k]), 32'(ad));
    check({req, " io_m"}, 32'(r_io[k]), 32'(io));
    check("R3 ad_oe in T1", 32'(r_oe[k]), 32'd1);
  endtask

  logic [15:0] exp_pc = 16'h0000;
  logic [15:0] exp_sp = 16'h0F00;
  logic [7:0]  exp_a  = 8'h00;

  task automatic finish_instr();
    @ev_done;
    @(negedge clk);
  endtask

  // R5: pop C1h
  task automatic t_pop(input int w, input logic [7:0] lo, input logic [7:0] hi);
    nwait = w;
    finish_instr();
    check("R5 length", 32'(r_len), 32'(10 + 3 * w));
    check("R5 cycle count", 32'(r_ncyc), 32'd3);
    check_cyc("R2 fetch", 0, 2'd0, exp_pc, 1'b0);
    check_cyc("R5 first pop", 1, 2'd1, exp_sp, 1'b0);
    check_cyc("R5 second pop", 2, 2'd1, exp_sp + 16'd1, 1'b0);
    check("R5 C gets first byte", 32'(c_q), 32'(lo));
    check("R5 B gets second byte", 32'(b_q), 32'(hi));
    exp_sp = exp_sp + 16'd2;
    exp_pc = exp_pc + 16'd1;
    check("R5 sp", 32'(sp_q), 32'(exp_sp));
    check("R2 pc", 32'(pc_q), 32'(exp_pc));
  endtask

  // R6: direct load 3Ah
  task automatic t_lda(input int w, input logic [15:0] ea, input logic [7:0] val);
    nwait = w;
    finish_instr();
    check("R6 length", 32'(r_len), 32'(13 + 4 * w));
    check("R6 cycle count", 32'(r_ncyc), 32'd4);
    check_cyc("R2 fetch", 0, 2'd0, exp_pc, 1'b0);
    check_cyc("R6 low operand", 1, 2'd1, exp_pc + 16'd1, 1'b0);
    check_cyc("R6 high operand", 2, 2'd1, exp_pc + 16'd2, 1'b0);
    check_cyc("R6 data read", 3, 2'd1, ea, 1'b0);
    exp_a  = val;
    exp_pc = exp_pc + 16'd3;
    check("R6 accumulator", 32'(acc_q), 32'(exp_a));
    check("R6 pc", 32'(pc_q), 32'(exp_pc));
  endtask

  // R7: port write D3h
  task automatic t_out(input int w, input logic [7:0] p);
    nwait = w;
    finish_instr();
    check("R7 length", 32'(r_len), 32'(10 + 3 * w));
    check("R7 cycle count", 32'(r_ncyc), 32'd3);
    check_cyc("R2 fetch", 0, 2'd0, exp_pc, 1'b0);
    check_cyc("R7 port byte read", 1, 2'd1, exp_pc + 16'd1, 1'b0);
    check_cyc("R8 io write", 2, 2'd3, {p, p}, 1'b1);
    check("R7 write seen", 32'(r_ws), 32'd1);
    check("R7 write data", 32'(r_wd), 32'(exp_a));
    check("R7 port", 32'(r_wp), 32'(p));
    exp_pc = exp_pc + 16'd2;
    check("R7 pc", 32'(pc_q), 32'(exp_pc));
  endtask

  // R2: undefined opcode
  task automatic t_nop(input int w);
    nwait = w;
    finish_instr();
    check("R2 undefined length", 32'(r_len), 32'(4 + w));
    check("R2 undefined cycle count", 32'(r_ncyc), 32'd1);
    check_cyc("R2 fetch", 0, 2'd0, exp_pc, 1'b0);
    exp_pc = exp_pc + 16'd1;
    check("R2 pc", 32'(pc_q), 32'(exp_pc));
    check("R9 registers kept", 32'({acc_q, b_q, c_q}), 32'({exp_a, 8'h22, 8'h11}));
  endtask

  task automatic check_reset_state();
    check("R1 ale", 32'(ale), 32'd0);
    check("R1 rd_n", 32'(rd_n), 32'd1);
    check("R1 wr_n", 32'(wr_n), 32'd1);
    check("R1 done", 32'(done), 32'd0);
    check("R1 pc", 32'(pc_q), 32'h0000);
    check("R1 sp", 32'(sp_q), 32'h0F00);
  endtask

  // R1: reset in the middle of an instruction
  task automatic t_reset_mid();
    nwait = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    @(posedge clk);
    #1 rst_n = 1'b1;
    exp_pc = 16'h0000;
    exp_sp = 16'h0F00;
  endtask

  bit finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h000] = 8'hC1;
    mem[12'h001] = 8'h3A; mem[12'h002] = 8'h34; mem[12'h003] = 8'h02;
    mem[12'h004] = 8'hD3; mem[12'h005] = 8'h42;
    mem[12'h006] = 8'hC1;
    mem[12'h007] = 8'h3A; mem[12'h008] = 8'h00; mem[12'h009] = 8'h03;
    mem[12'h00A] = 8'h00;
    mem[12'h00B] = 8'hD3; mem[12'h00C] = 8'hFF;
    mem[12'h00D] = 8'h3A; mem[12'h00E] = 8'h00; mem[12'h00F] = 8'h03;
    mem[12'h234] = 8'h77;
    mem[12'h300] = 8'h99;
    mem[12'hF00] = 8'h5A; mem[12'hF01] = 8'hA5;
    mem[12'hF02] = 8'h11; mem[12'hF03] = 8'h22;

    repeat (3) @(negedge clk);
    check_reset_state();
    @(posedge clk);
    #1 rst_n = 1'b1;

    t_pop(0, 8'h5A, 8'hA5);           // R5 no waits
    t_lda(0, 16'h0234, 8'h77);        // R6 no waits
    t_out(0, 8'h42);                  // R7 no waits
    t_pop(1, 8'h11, 8'h22);           // R4 one wait per cycle
    t_lda(2, 16'h0300, 8'h99);        // R4 two waits per cycle
    t_nop(0);                         // R2 undefined opcode
    t_out(1, 8'hFF);                  // R7 with waits
    t_reset_mid();                    // R1 mid-instruction reset
    t_pop(0, 8'h5A, 8'hA5);           // R1 restart from 0000h
    check("R10 strobes never both low", 32'(both_low), 32'd0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule